// File: doc/BRIEF.md
# Cascadable Serial Dot-Correction Register

This block is the serial set-up path of a sixteen-channel LED current driver. While the bank-select line is low, each rising edge of the shift clock pushes one serial bit into a 128-bit chain. The bit that leaves the far end of the chain drives the serial output, so several drivers can share one data line. The first bit entering a device leaves it again after 128 edges and moves on to the next device. In a chain of two devices, 256 edges fill both, and the earliest data ends up in the second device.

A rising edge on the latch strobe, seen while the bank-select line is low, copies the chain into a holding bank. The holding bank feeds one 6-bit adjustment value per channel. Each channel owns an 8-bit slot in the stream: channel 15 comes first and channel 0 last, each slot is sent MSB first, and the top two bits of every slot are discarded. The shift clock is the block clock. The latch strobe and the select line are sampled on that clock.

Top module: `dot_corr_serial`

## Requirements
- R1: While reset is low, and on the first edges after reset is released, the serial output and every adjustment output read 0. Reset also empties the chain, so until 128 bits have been shifted in after a reset the serial output shows only zeros.
- R2: On each rising clock edge with the bank-select input low, the serial input enters the chain.
- R3: The serial output shows the bit that was shifted in 128 shift edges earlier.
- R4: After 128 bits are shifted and latched, the adjustment output for channel k (bits 6k+5 down to 6k) equals the low six bits of the k-th 8-bit slot counted from the end of the stream. The first slot belongs to channel 15, and each slot is sent MSB first.
- R5: The two most-significant bits of each 8-bit slot have no effect on any adjustment output.
- R6: The holding bank loads at the edge where the latch strobe is sampled high after being sampled low, with select low. The new values appear at the adjustment outputs right after that edge. At every other edge, including while the strobe stays high, the adjustment outputs stay unchanged. The bit shifted on the latch edge itself does not enter the loaded values.
- R7: While bank-select is high, the chain and the serial output are frozen and latch strobes are ignored. Shifting carries on from the frozen state once select goes low again.
- R8: With two devices chained serial output to serial input, after 256 shifts and one latch, the second device holds the first 128 bits and the first device holds the last 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data in |
| latch_i | input | 1 | Latch strobe, rising edge loads the holding bank |
| bank_sel_i | input | 1 | Bank select, low selects the dot-correction chain |
| sdo_o | output | 1 | Serial data out, for the next device in the chain |
| adj_o | output | 96 | Sixteen 6-bit adjustment values, channel k at bits 6k+5:6k |

## Verification
The bound checker watches, at every edge, that a new bit enters the chain head and that the tail moves one place toward the output. It also checks that the select-high freeze holds both outputs still, that the holding bank changes only on a qualified strobe edge, and that the fields of channels 0 and 15 load from the right chain positions. Other behaviour shows only over whole scenarios: the 128-edge delay of the serial output, the channel order and the discarded bits across all sixteen slots, the way a two-device chain splits the data, and the chain surviving a frozen stretch. The bench covers these by sweeping value patterns and comparing against a shifted-bit history.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  parameter int unsigned DCR_NUM_CH = 16;
  parameter int unsigned DCR_SLOT_W = 8;
  parameter int unsigned DCR_ADJ_W  = 6;
endpackage

// File: rtl/dcr_rst_sync.sv
module dcr_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= stage_d;
  end

  assign rst_sync_n_o = stage_q[1];
endmodule

// File: rtl/dcr_shift_chain.sv
module dcr_shift_chain #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             shift_en_i,
  input  logic             sdi_i,
  output logic [WIDTH-1:0] chain_o
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en_i) chain_d = {chain_q[WIDTH-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/dcr_latch_ctrl.sv
module dcr_latch_ctrl (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic latch_i,
  input  logic bank_sel_i,
  output logic load_o
);
  // Held at 1 in reset: a strobe already high at release is not an edge.
  logic latch_q;
  logic latch_d;

  always_comb begin
    latch_d = latch_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) latch_q <= 1'b1;
    else          latch_q <= latch_d;
  end

  assign load_o = latch_i & ~latch_q & ~bank_sel_i;
endmodule

// File: rtl/dcr_hold_bank.sv
module dcr_hold_bank #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned ADJ_W  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     load_i,
  input  logic [NUM_CH*SLOT_W-1:0] chain_i,
  output logic [NUM_CH*ADJ_W-1:0]  adj_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ADJ_W-1:0] hold_q;
    logic [ADJ_W-1:0] hold_d;

    always_comb begin
      hold_d = hold_q;
      // The upper SLOT_W-ADJ_W bits of the slot are dropped here.
      if (load_i) hold_d = chain_i[ch*SLOT_W +: ADJ_W];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) hold_q <= '0;
      else          hold_q <= hold_d;
    end

    assign adj_o[ch*ADJ_W +: ADJ_W] = hold_q;
  end
endmodule

// File: rtl/dot_corr_serial.sv
module dot_corr_serial
  import dcr_pkg::*;
#(
  parameter int unsigned NUM_CH = DCR_NUM_CH,
  parameter int unsigned SLOT_W = DCR_SLOT_W,
  parameter int unsigned ADJ_W  = DCR_ADJ_W
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic                    sdi_i,
  input  logic                    latch_i,
  input  logic                    bank_sel_i,
  output logic                    sdo_o,
  output logic [NUM_CH*ADJ_W-1:0] adj_o
);
  localparam int unsigned CHAIN_W = NUM_CH * SLOT_W;

  logic               rst_sync_n;
  logic               shift_en;
  logic               load_en;
  logic [CHAIN_W-1:0] chain_q;

  assign shift_en = ~bank_sel_i;

  dcr_rst_sync u_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  dcr_shift_chain #(.WIDTH(CHAIN_W)) u_chain (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .shift_en_i (shift_en),
    .sdi_i      (sdi_i),
    .chain_o    (chain_q)
  );

  dcr_latch_ctrl u_latch (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .latch_i    (latch_i),
    .bank_sel_i (bank_sel_i),
    .load_o     (load_en)
  );

  dcr_hold_bank #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .ADJ_W(ADJ_W)) u_hold (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .load_i  (load_en),
    .chain_i (chain_q),
    .adj_o   (adj_o)
  );

  assign sdo_o = chain_q[CHAIN_W-1];
endmodule

// File: rtl/dot_corr_serial_chk.sv
module dot_corr_serial_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned ADJ_W  = 6
) (
  input logic                      clk_i,
  input logic                      rst_n_i,
  input logic                      rst_s_n,
  input logic                      sdi_i,
  input logic                      latch_i,
  input logic                      bank_sel_i,
  input logic                      sdo_o,
  input logic [NUM_CH*ADJ_W-1:0]   adj_o,
  input logic [NUM_CH*SLOT_W-1:0]  chain_i
);
  localparam int unsigned CHAIN_W = NUM_CH * SLOT_W;
  localparam int unsigned TOP_LSB = CHAIN_W - SLOT_W;
  localparam int unsigned OUT_W   = NUM_CH * ADJ_W;

  logic armed_q;
  logic prev_lat_q;
  logic rise_evt;

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      armed_q    <= 1'b0;
      prev_lat_q <= 1'b1;
    end else begin
      armed_q    <= 1'b1;
      prev_lat_q <= latch_i;
    end
  end

  assign rise_evt = latch_i & ~prev_lat_q & ~bank_sel_i;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rst_s_n) |-> (sdo_o == 1'b0 && adj_o == '0)); // R1

  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && !bank_sel_i) |=> (chain_i[0] == $past(sdi_i))); // R2

  AST_TAIL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && !bank_sel_i) |=> (sdo_o == $past(chain_i[CHAIN_W-2]))); // R3

  AST_FREEZE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && bank_sel_i) |=> ($stable(sdo_o) && $stable(adj_o))); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && !rise_evt) |=> $stable(adj_o)); // R6

  AST_LOAD_LOW_CH: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && rise_evt) |=> (adj_o[ADJ_W-1:0] == $past(chain_i[ADJ_W-1:0]))); // R5

  AST_LOAD_TOP_CH: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (armed_q && rise_evt) |=>
      (adj_o[OUT_W-1 -: ADJ_W] == $past(chain_i[TOP_LSB +: ADJ_W]))); // R4
endmodule

bind dot_corr_serial dot_corr_serial_chk #(
  .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .ADJ_W(ADJ_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .rst_s_n    (rst_sync_n),
  .sdi_i      (sdi_i),
  .latch_i    (latch_i),
  .bank_sel_i (bank_sel_i),
  .sdo_o      (sdo_o),
  .adj_o      (adj_o),
  .chain_i    (chain_q)
);

// File: tb/test_dot_corr_serial.sv
module test_dot_corr_serial;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int SW  = 8;
  localparam int AW  = 6;
  localparam int CW  = NCH * SW;

  logic clk = 1'b0;
  logic rst_n, sdi, latch, sel;
  logic sdo_a, sdo_b;
  logic [NCH*AW-1:0] adj_a, adj_b;

  int checks = 0;
  int fails  = 0;
  bit hist [0:4095];
  int n_shift = 0;
  int base = 0;
  int pv [NCH];
  int pj [NCH];
  int prev_pv [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dot_corr_serial i_dot_corr_serial (
    .clk_i(clk), .rst_n_i(rst_n), .sdi_i(sdi), .latch_i(latch),
    .bank_sel_i(sel), .sdo_o(sdo_a), .adj_o(adj_a));

  dot_corr_serial i_dot_corr_serial_b (
    .clk_i(clk), .rst_n_i(rst_n), .sdi_i(sdo_a), .latch_i(latch),
    .bank_sel_i(sel), .sdo_o(sdo_b), .adj_o(adj_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hbit(input int idx);
    return (idx >= base) ? hist[idx] : 1'b0;
  endfunction

  // Field of channel ch for device dev (0 = first, 1 = second) after n bits
  function automatic int exp_field(input int dev, input int ch, input int n);
    int v = 0;
    for (int i = 0; i < AW; i++)
      if (hbit(n - 1 - (ch*SW + i) - dev*CW)) v |= (1 << i);
    return v;
  endfunction

  task automatic shift_one(input logic b, input logic lat);
    sdi = b; sel = 1'b0; latch = lat;
    @(posedge clk);
    hist[n_shift] = b;
    n_shift++;
    @(negedge clk);
    // R2 R3: each shifted bit reaches sdo 128 edges later, zeros before
    chk(sdo_a == hbit(n_shift - CW), "R3 sdo first device", sdo_a, hbit(n_shift - CW));
    chk(sdo_b == hbit(n_shift - 2*CW), "R2 sdo second device", sdo_b, hbit(n_shift - 2*CW));
  endtask

  task automatic load_stream(input logic lat);
    for (int ch = NCH-1; ch >= 0; ch--) begin
      logic [SW-1:0] slot;
      slot = SW'((pj[ch] << AW) | pv[ch]);
      for (int b = SW-1; b >= 0; b--) shift_one(slot[b], lat);
    end
  endtask

  task automatic do_latch();
    int ea [NCH];
    int eb [NCH];
    for (int ch = 0; ch < NCH; ch++) begin
      ea[ch] = exp_field(0, ch, n_shift);
      eb[ch] = exp_field(1, ch, n_shift);
    end
    shift_one(1'b0, 1'b1);
    for (int ch = 0; ch < NCH; ch++) begin
      chk(int'(adj_a[ch*AW +: AW]) == ea[ch], "R6 immediate load dev a", adj_a[ch*AW +: AW], ea[ch]);
      chk(int'(adj_b[ch*AW +: AW]) == eb[ch], "R6 immediate load dev b", adj_b[ch*AW +: AW], eb[ch]);
    end
  endtask

  task automatic check_vals(input logic [NCH*AW-1:0] adj, input string req);
    for (int ch = 0; ch < NCH; ch++)
      chk(int'(adj[ch*AW +: AW]) == pv[ch], req, adj[ch*AW +: AW], pv[ch]);
  endtask

  task automatic set_pattern(input int seed);
    for (int ch = 0; ch < NCH; ch++) begin
      pv[ch] = (seed == 5) ? 63 : ((ch*seed*5 + seed*7 + ch) & 63);
      pj[ch] = (seed + ch) & 3;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; sel = 1'b1; latch = 1'b0; sdi = 1'b0;
    #1;
    // R1: asynchronous clear seen at once
    chk(sdo_a == 1'b0 && sdo_b == 1'b0, "R1 sdo in reset", sdo_a, 0);
    chk(adj_a == '0 && adj_b == '0, "R1 adj in reset", adj_a, 0);
    repeat (2) @(negedge clk);
    base = n_shift;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(adj_a == '0 && sdo_a == 1'b0, "R1 after release", adj_a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL WATCHDOG run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b1; latch = 1'b0; sdi = 1'b0;
    apply_reset();

    // R4 R6: sweep of value patterns, each loaded and latched
    for (int seed = 0; seed < 6; seed++) begin
      set_pattern(seed);
      load_stream(1'b0);
      do_latch();
      check_vals(adj_a, "R4 channel order");
    end

    // R5: same values with different discarded bits give same outputs
    for (int ch = 0; ch < NCH; ch++) pj[ch] = 3 - pj[ch];
    load_stream(1'b0);
    do_latch();
    check_vals(adj_a, "R5 discarded bits");
    for (int ch = 0; ch < NCH; ch++) prev_pv[ch] = pv[ch];

    // R6: strobe held high while a new stream arrives: no reload
    set_pattern(2);
    latch = 1'b1;
    load_stream(1'b1);
    for (int ch = 0; ch < NCH; ch++)
      chk(int'(adj_a[ch*AW +: AW]) == prev_pv[ch], "R6 held strobe", adj_a[ch*AW +: AW], prev_pv[ch]);
    shift_one(1'b1, 1'b0);

    // R7: select high freezes chain and ignores the strobe
    begin
      logic s0;
      logic [NCH*AW-1:0] a0;
      s0 = sdo_a; a0 = adj_a;
      for (int i = 0; i < 8; i++) begin
        sel = 1'b1; sdi = i[0]; latch = i[0];
        @(posedge clk);
        @(negedge clk);
        chk(sdo_a == s0, "R7 sdo frozen", sdo_a, s0);
        chk(adj_a == a0, "R7 latch ignored", adj_a, a0);
      end
      latch = 1'b0;
    end
    // Shifting resumes from frozen contents (checked by sdo history)
    for (int i = 0; i < 40; i++) shift_one(1'(i % 3 == 0), 1'b0);

    // R8: two streams back to back, then one latch
    set_pattern(3);
    load_stream(1'b0);
    for (int ch = 0; ch < NCH; ch++) prev_pv[ch] = pv[ch];
    set_pattern(4);
    load_stream(1'b0);
    do_latch();
    check_vals(adj_a, "R8 first device holds last data");
    for (int ch = 0; ch < NCH; ch++)
      chk(int'(adj_b[ch*AW +: AW]) == prev_pv[ch], "R8 second device holds first data",
          adj_b[ch*AW +: AW], prev_pv[ch]);

    // R1: reset mid-run clears everything, sdo zeros until refilled
    apply_reset();
    set_pattern(1);
    load_stream(1'b0);
    do_latch();
    check_vals(adj_a, "R1 reload after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule